// File: doc/BRIEF.md
# Buffered Matrix Multiply Engine

The engine multiplies two square matrices of signed 32-bit integers. The matrix size is chosen at run time. Each operand lives in external memory as a flat row-major sequence of words, and all traffic goes through one shared memory port. That port has a burst read channel and a burst write channel. Each channel has a request handshake that carries a start address and a length, and a data stream with valid/ready.

A job is launched with a one-cycle start pulse. The job runs in four phases:

- The whole first operand is fetched into an on-chip buffer.
- The whole second operand is fetched into another on-chip buffer.
- Every output element is computed by a pipelined multiply-accumulate datapath into a third buffer. The datapath issues one product per clock.
- The complete result is written back as one burst.

A one-cycle done pulse ends the job.

Because the two operands are fetched in separate back-to-back bursts rather than interleaved, each transfer phase moves one word per clock whenever the memory side is ready.

Top module: `mm_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req_valid` and `wr_req_valid` are low. A `start` pulse while idle latches `dim_in`, `base_a`, `base_b` and `base_c`. `busy` is high from the next cycle until the cycle after `done`.
- R2: The first operand is fetched with exactly one read request at `base_a` with length dim×dim words. Addresses count words, and element (i,j) sits at base + i·dim + j. During a read data phase `rd_data_ready` stays high, so every offered beat is taken in the cycle it is offered.
- R3: The read request for the second operand, at `base_b` with length dim×dim, is raised only after all dim×dim beats of the first operand have been accepted.
- R4: Each result word (i,j) equals the sum over k of first[i][k]·second[k][j], computed in two's complement and kept modulo 2^32.
- R5: The result is written with one write request at `base_c` with length dim×dim. The request is raised only after every result element has been computed. The data follows in row-major order, and `wr_data_valid` stays high until the last beat is taken.
- R6: `done` is high for exactly one cycle: the cycle right after the clock edge that accepts the last write beat.
- R7: A `dim_in` of zero raises `done` in the cycle after `start`, and no read or write request is issued.
- R8: A `dim_in` above `MAX_DIM` is treated as `MAX_DIM`.
- R9: A raised read or write request keeps its address and length stable until it is accepted.
- R10: A `start` pulse while a job is running has no effect on that job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, honoured only while idle |
| dim_in | input | CFG_W | Requested matrix dimension |
| base_a | input | ADDR_W | Word address of the first operand |
| base_b | input | ADDR_W | Word address of the second operand |
| base_c | input | ADDR_W | Word address of the result |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_req_valid | output | 1 | Read burst request valid |
| rd_req_ready | input | 1 | Read burst request accepted |
| rd_req_addr | output | ADDR_W | Read burst start word address |
| rd_req_len | output | LEN_W | Read burst length in words |
| rd_data_valid | input | 1 | Read data beat valid |
| rd_data_ready | output | 1 | Engine takes read data |
| rd_data | input | 32 | Read data word |
| wr_req_valid | output | 1 | Write burst request valid |
| wr_req_ready | input | 1 | Write burst request accepted |
| wr_req_addr | output | ADDR_W | Write burst start word address |
| wr_req_len | output | LEN_W | Write burst length in words |
| wr_data_valid | output | 1 | Write data beat valid |
| wr_data_ready | input | 1 | Memory takes write data |
| wr_data | output | 32 | Write data word |

## Verification
The bench builds the engine with `MAX_DIM` = 8, `CFG_W` = 8 and 32-bit addresses. With these values a full-size job (64 words per operand, 512 multiply-accumulates) finishes in a few hundred cycles, which leaves room for many jobs under random ready stalls.

The reduced maximum brings clamping within reach with a plain request of 10, and it lets the three buffers be checked at their full extent. A dimension of 1 exercises the case where the first and last multiply-accumulate of an element fall on the same beat. Full-range random operands exercise wrap-around of both products and sums.

// File: rtl/mm_pkg.sv
package mm_pkg;

  localparam int ELEM_W = 32;

  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RDA_REQ,
    S_RDA_DAT,
    S_RDB_REQ,
    S_RDB_DAT,
    S_MAC,
    S_DRAIN,
    S_WR_REQ,
    S_WR_DAT,
    S_DONE
  } state_e;

  // Signed product truncated to the element width (wraps modulo 2^32).
  function automatic elem_t mul_wrap(elem_t a, elem_t b);
    return elem_t'($signed(a) * $signed(b));
  endfunction

  // One accumulation step: the first term of a dot product replaces the sum.
  function automatic elem_t acc_step(logic first, elem_t acc, elem_t prod);
    return first ? prod : elem_t'(acc + prod);
  endfunction

endpackage

// File: rtl/mm_buf.sv
module mm_buf #(
  parameter int DEPTH = 4096,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  mm_pkg::elem_t   wdata,
  input  logic [AW-1:0]   raddr,
  output mm_pkg::elem_t   rdata
);

  mm_pkg::elem_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/mm_index_gen.sv
module mm_index_gen #(
  parameter int MAX_DIM = 64,
  localparam int DIM_W  = $clog2(MAX_DIM + 1),
  localparam int IDX_W  = $clog2(MAX_DIM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [DIM_W-1:0] dim,
  output logic [IDX_W-1:0] row,
  output logic [IDX_W-1:0] col,
  output logic             col_end,
  output logic             at_end
);

  logic [DIM_W-1:0] dim_m1;

  assign dim_m1  = dim - DIM_W'(1);
  assign col_end = (DIM_W'(col) == dim_m1);
  assign at_end  = col_end && (DIM_W'(row) == dim_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (clr) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      if (col_end) begin
        col <= '0;
        row <= row + IDX_W'(1);
      end else begin
        col <= col + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/mm_mac_pipe.sv
module mm_mac_pipe #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_first,
  input  logic          in_last,
  input  mm_pkg::elem_t in_a,
  input  mm_pkg::elem_t in_b,
  input  logic [AW-1:0] in_dst,
  output logic          out_vld,
  output mm_pkg::elem_t out_data,
  output logic [AW-1:0] out_dst,
  output logic          busy
);

  import mm_pkg::*;

  logic          p_vld, p_first, p_last;
  elem_t         p_prod;
  logic [AW-1:0] p_dst;
  elem_t         acc_q;
  elem_t         acc_nxt;

  // Stage 1: product register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld   <= 1'b0;
      p_first <= 1'b0;
      p_last  <= 1'b0;
      p_prod  <= '0;
      p_dst   <= '0;
    end else begin
      p_vld   <= in_vld;
      p_first <= in_first;
      p_last  <= in_last;
      p_prod  <= mul_wrap(in_a, in_b);
      p_dst   <= in_dst;
    end
  end

  assign acc_nxt = acc_step(p_first, acc_q, p_prod);

  // Stage 2: accumulator, emits the finished sum on the last term
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q    <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
      out_dst  <= '0;
    end else begin
      if (p_vld) acc_q <= acc_nxt;
      out_vld  <= p_vld && p_last;
      out_data <= acc_nxt;
      out_dst  <= p_dst;
    end
  end

  assign busy = p_vld || out_vld;

endmodule

// File: rtl/mm_engine.sv
module mm_engine #(
  parameter int MAX_DIM = 64,
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 8,
  localparam int DIM_W  = $clog2(MAX_DIM + 1),
  localparam int IDX_W  = $clog2(MAX_DIM),
  localparam int DEPTH  = MAX_DIM * MAX_DIM,
  localparam int BUF_AW = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [CFG_W-1:0]          dim_in,
  input  logic [ADDR_W-1:0]         base_a,
  input  logic [ADDR_W-1:0]         base_b,
  input  logic [ADDR_W-1:0]         base_c,
  output logic                      busy,
  output logic                      done,
  output logic                      rd_req_valid,
  input  logic                      rd_req_ready,
  output logic [ADDR_W-1:0]         rd_req_addr,
  output logic [LEN_W-1:0]          rd_req_len,
  input  logic                      rd_data_valid,
  output logic                      rd_data_ready,
  input  logic [mm_pkg::ELEM_W-1:0] rd_data,
  output logic                      wr_req_valid,
  input  logic                      wr_req_ready,
  output logic [ADDR_W-1:0]         wr_req_addr,
  output logic [LEN_W-1:0]          wr_req_len,
  output logic                      wr_data_valid,
  input  logic                      wr_data_ready,
  output logic [mm_pkg::ELEM_W-1:0] wr_data
);

  import mm_pkg::*;

  localparam int NBUF = 3;
  localparam int BUF_A = 0;
  localparam int BUF_B = 1;
  localparam int BUF_C = 2;

  function automatic logic [DIM_W-1:0] clamp_dim(logic [CFG_W-1:0] d);
    if (d > CFG_W'(MAX_DIM)) return DIM_W'(MAX_DIM);
    return DIM_W'(d);
  endfunction

  function automatic logic [BUF_AW-1:0] lin(logic [IDX_W-1:0] r, logic [IDX_W-1:0] c);
    return BUF_AW'(r) * BUF_AW'(MAX_DIM) + BUF_AW'(c);
  endfunction

  // Job registers
  state_e            state_q, state_d;
  logic [DIM_W-1:0]  dim_q;
  logic [LEN_W-1:0]  total_q;
  logic [ADDR_W-1:0] base_a_q, base_b_q, base_c_q;
  logic [DIM_W-1:0]  dim_c;

  // Named events used by the checker
  logic start_ok;
  logic rd_beat;
  logic wr_beat;
  logic mac_issue;
  logic mac_res_vld;

  // Transfer index generator (shared by all three bursts)
  logic             xf_clr, xf_step, xf_col_end, xf_end;
  logic [IDX_W-1:0] xf_row, xf_col;

  // Compute indices
  logic             ij_clr, ij_step, j_end, ij_end;
  logic [IDX_W-1:0] i_q, j_q, k_q;
  logic             k_last;

  // Buffers
  logic              buf_we    [NBUF];
  logic [BUF_AW-1:0] buf_waddr [NBUF];
  elem_t             buf_wdata [NBUF];
  logic [BUF_AW-1:0] buf_raddr [NBUF];
  elem_t             buf_rdata [NBUF];

  // MAC pipe
  elem_t             mac_data;
  logic [BUF_AW-1:0] mac_dst;
  logic              mac_busy;

  assign dim_c     = clamp_dim(dim_in);
  assign start_ok  = start && (state_q == S_IDLE);
  assign rd_beat   = rd_data_valid && rd_data_ready;
  assign wr_beat   = wr_data_valid && wr_data_ready;
  assign mac_issue = (state_q == S_MAC);

  assign xf_clr  = (state_q == S_RDA_REQ) || (state_q == S_RDB_REQ) || (state_q == S_WR_REQ);
  assign xf_step = rd_beat || wr_beat;

  assign ij_clr  = (state_q == S_RDB_REQ);
  assign k_last  = (DIM_W'(k_q) == dim_q - DIM_W'(1));
  assign ij_step = mac_issue && k_last;

  mm_index_gen #(.MAX_DIM(MAX_DIM)) u_xf_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (xf_clr),
    .step    (xf_step),
    .dim     (dim_q),
    .row     (xf_row),
    .col     (xf_col),
    .col_end (xf_col_end),
    .at_end  (xf_end)
  );

  mm_index_gen #(.MAX_DIM(MAX_DIM)) u_out_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ij_clr),
    .step    (ij_step),
    .dim     (dim_q),
    .row     (i_q),
    .col     (j_q),
    .col_end (j_end),
    .at_end  (ij_end)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q <= '0;
    end else if (ij_clr) begin
      k_q <= '0;
    end else if (mac_issue) begin
      k_q <= k_last ? '0 : k_q + IDX_W'(1);
    end
  end

  // Job latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_q    <= '0;
      total_q  <= '0;
      base_a_q <= '0;
      base_b_q <= '0;
      base_c_q <= '0;
    end else if (start_ok) begin
      dim_q    <= dim_c;
      total_q  <= LEN_W'(dim_c) * LEN_W'(dim_c);
      base_a_q <= base_a;
      base_b_q <= base_b;
      base_c_q <= base_c;
    end
  end

  // Phase sequencer
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (start_ok) state_d = (dim_c == '0) ? S_DONE : S_RDA_REQ;
      S_RDA_REQ: if (rd_req_ready) state_d = S_RDA_DAT;
      S_RDA_DAT: if (rd_beat && xf_end) state_d = S_RDB_REQ;
      S_RDB_REQ: if (rd_req_ready) state_d = S_RDB_DAT;
      S_RDB_DAT: if (rd_beat && xf_end) state_d = S_MAC;
      S_MAC:     if (ij_step && ij_end) state_d = S_DRAIN;
      S_DRAIN:   if (!mac_busy) state_d = S_WR_REQ;
      S_WR_REQ:  if (wr_req_ready) state_d = S_WR_DAT;
      S_WR_DAT:  if (wr_beat && xf_end) state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Buffer port wiring
  always_comb begin
    buf_we[BUF_A]    = rd_beat && (state_q == S_RDA_DAT);
    buf_waddr[BUF_A] = lin(xf_row, xf_col);
    buf_wdata[BUF_A] = rd_data;
    buf_raddr[BUF_A] = lin(i_q, k_q);

    buf_we[BUF_B]    = rd_beat && (state_q == S_RDB_DAT);
    buf_waddr[BUF_B] = lin(xf_row, xf_col);
    buf_wdata[BUF_B] = rd_data;
    buf_raddr[BUF_B] = lin(k_q, j_q);

    buf_we[BUF_C]    = mac_res_vld;
    buf_waddr[BUF_C] = mac_dst;
    buf_wdata[BUF_C] = mac_data;
    buf_raddr[BUF_C] = lin(xf_row, xf_col);
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    mm_buf #(.DEPTH(DEPTH), .AW(BUF_AW)) u_buf (
      .clk   (clk),
      .we    (buf_we[g]),
      .waddr (buf_waddr[g]),
      .wdata (buf_wdata[g]),
      .raddr (buf_raddr[g]),
      .rdata (buf_rdata[g])
    );
  end

  mm_mac_pipe #(.AW(BUF_AW)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (mac_issue),
    .in_first (k_q == '0),
    .in_last  (k_last),
    .in_a     (buf_rdata[BUF_A]),
    .in_b     (buf_rdata[BUF_B]),
    .in_dst   (lin(i_q, j_q)),
    .out_vld  (mac_res_vld),
    .out_data (mac_data),
    .out_dst  (mac_dst),
    .busy     (mac_busy)
  );

  // Port outputs
  assign busy          = (state_q != S_IDLE);
  assign done          = (state_q == S_DONE);
  assign rd_req_valid  = (state_q == S_RDA_REQ) || (state_q == S_RDB_REQ);
  assign rd_req_addr   = (state_q == S_RDB_REQ) ? base_b_q : base_a_q;
  assign rd_req_len    = total_q;
  assign rd_data_ready = (state_q == S_RDA_DAT) || (state_q == S_RDB_DAT);
  assign wr_req_valid  = (state_q == S_WR_REQ);
  assign wr_req_addr   = base_c_q;
  assign wr_req_len    = total_q;
  assign wr_data_valid = (state_q == S_WR_DAT);
  assign wr_data       = buf_rdata[BUF_C];

endmodule

// File: rtl/mm_engine_sva.sv
module mm_engine_sva #(
  parameter int MAX_DIM = 64,
  parameter int ADDR_W  = 32,
  parameter int CFG_W   = 8,
  localparam int LEN_W  = $clog2(MAX_DIM * MAX_DIM + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input mm_pkg::state_e    state_q,
  input logic              start,
  input logic [CFG_W-1:0]  dim_in,
  input logic              done,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic [LEN_W-1:0]  rd_req_len,
  input logic              wr_req_valid,
  input logic              wr_req_ready,
  input logic [ADDR_W-1:0] wr_req_addr,
  input logic [LEN_W-1:0]  wr_req_len,
  input logic              rd_beat,
  input logic              mac_res_vld
);

  import mm_pkg::*;

  int unsigned rd_cnt;
  int unsigned res_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt  <= 0;
      res_cnt <= 0;
    end else if (state_q == S_IDLE) begin
      rd_cnt  <= 0;
      res_cnt <= 0;
    end else begin
      if (rd_beat)     rd_cnt  <= rd_cnt + 1;
      if (mac_res_vld) res_cnt <= res_cnt + 1;
    end
  end

  AST_RD_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> rd_cnt == 2 * int'(wr_req_len)); // R2

  AST_SECOND_AFTER_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && state_q == S_RDB_REQ) |-> rd_cnt == int'(rd_req_len)); // R3

  AST_WB_AFTER_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_valid |-> res_cnt == int'(wr_req_len)); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_ZERO_DIM: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == S_IDLE && dim_in == '0) |=> (done && !rd_req_valid && !wr_req_valid)); // R7

  AST_RD_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr) && $stable(rd_req_len))); // R9

  AST_WR_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=> (wr_req_valid && $stable(wr_req_addr) && $stable(wr_req_len))); // R9

  AST_JOB_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> (state_q == S_IDLE || $stable(rd_req_len))); // R10

endmodule

bind mm_engine mm_engine_sva #(
  .MAX_DIM (MAX_DIM),
  .ADDR_W  (ADDR_W),
  .CFG_W   (CFG_W)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .state_q      (state_q),
  .start        (start),
  .dim_in       (dim_in),
  .done         (done),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .rd_req_len   (rd_req_len),
  .wr_req_valid (wr_req_valid),
  .wr_req_ready (wr_req_ready),
  .wr_req_addr  (wr_req_addr),
  .wr_req_len   (wr_req_len),
  .rd_beat      (rd_beat),
  .mac_res_vld  (mac_res_vld)
);

// File: tb/mm_engine_bench.sv
module mm_engine_bench;

  localparam int MAXD = 8;
  localparam int AW   = 32;
  localparam int CW   = 8;
  localparam int LW   = $clog2(MAXD * MAXD + 1);
  localparam int MEMW = 1024;
  localparam int BA   = 16;
  localparam int BB   = 200;
  localparam int BC   = 400;

  // Stimulus table: requested dimension and operand pattern (0 small, 1 full range)
  localparam int NVEC = 5;
  localparam int TBL_DIM [NVEC] = '{1, 3, 8, 10, 2};
  localparam int TBL_PAT [NVEC] = '{0, 0, 1, 0, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          start = 1'b0;
  logic [CW-1:0] dim_in = '0;
  logic [AW-1:0] base_a = AW'(BA);
  logic [AW-1:0] base_b = AW'(BB);
  logic [AW-1:0] base_c = AW'(BC);
  logic          busy, done;
  logic          rd_req_valid, rd_req_ready;
  logic [AW-1:0] rd_req_addr;
  logic [LW-1:0] rd_req_len;
  logic          rd_data_valid, rd_data_ready;
  logic [31:0]   rd_data;
  logic          wr_req_valid, wr_req_ready;
  logic [AW-1:0] wr_req_addr;
  logic [LW-1:0] wr_req_len;
  logic          wr_data_valid, wr_data_ready;
  logic [31:0]   wr_data;

  mm_engine #(.MAX_DIM(MAXD), .ADDR_W(AW), .CFG_W(CW)) u_mm_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_in(dim_in),
    .base_a(base_a), .base_b(base_b), .base_c(base_c),
    .busy(busy), .done(done),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_req_len(rd_req_len),
    .rd_data_valid(rd_data_valid), .rd_data_ready(rd_data_ready), .rd_data(rd_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready),
    .wr_req_addr(wr_req_addr), .wr_req_len(wr_req_len),
    .wr_data_valid(wr_data_valid), .wr_data_ready(wr_data_ready), .wr_data(wr_data)
  );

  logic [31:0] mem [MEMW];
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;

  // Responder log
  int rq_n, rq_addr [2], rq_len [2], rq_before [2];
  int rd_ptr, rd_left, rd_beats, last_rd_cyc, gap_rd;
  int wq_n, wq_addr, wq_len, wq_cyc;
  int wr_ptr, wr_left, wr_last_cyc, gap_wr, hold_err;

  task automatic clear_log();
    rq_n = 0; rd_beats = 0; last_rd_cyc = 0; gap_rd = 0;
    wq_n = 0; wq_addr = 0; wq_len = 0; wq_cyc = 0;
    wr_last_cyc = 0; gap_wr = 0; hold_err = 0;
    for (int i = 0; i < 2; i++) begin
      rq_addr[i] = -1; rq_len[i] = -1; rq_before[i] = -1;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Memory responder: acts only on the falling edge. The engine has no
  // combinational path from its inputs to its outputs, so a handshake decided
  // here is the one that happens at the next rising edge.
  initial begin : responder
    bit p_rq, p_rd, p_wq, p_wr, w_wait, r_wait;
    int p_addr, p_len, p_waddr, p_wlen, p_cyc, r_addr, w_addr;
    logic [31:0] p_wdata;
    p_rq = 0; p_rd = 0; p_wq = 0; p_wr = 0; r_wait = 0; w_wait = 0;
    rd_req_ready = 0; rd_data_valid = 0; rd_data = '0;
    wr_req_ready = 0; wr_data_ready = 0;
    rd_ptr = 0; rd_left = 0; wr_ptr = 0; wr_left = 0;
    r_addr = 0; w_addr = 0; p_addr = 0; p_len = 0; p_waddr = 0; p_wlen = 0;
    p_cyc = 0; p_wdata = '0;
    clear_log();
    forever begin
      @(negedge clk);
      if (p_rq) begin
        if (rq_n < 2) begin
          rq_addr[rq_n] = p_addr; rq_len[rq_n] = p_len; rq_before[rq_n] = rd_beats;
        end
        rq_n++; rd_ptr = p_addr; rd_left = p_len;
      end
      if (p_rd) begin
        rd_ptr++; rd_left--; rd_beats++; last_rd_cyc = p_cyc;
      end
      if (p_wq) begin
        wq_n++; wq_addr = p_waddr; wq_len = p_wlen; wq_cyc = p_cyc;
        wr_ptr = p_waddr; wr_left = p_wlen;
      end
      if (p_wr) begin
        mem[wr_ptr % MEMW] = p_wdata; wr_ptr++; wr_left--; wr_last_cyc = p_cyc;
      end
      // R9: a waiting request must not move
      if (r_wait && (!rd_req_valid || int'(rd_req_addr) != r_addr)) hold_err++;
      if (w_wait && (!wr_req_valid || int'(wr_req_addr) != w_addr)) hold_err++;
      if (!rst_n) begin
        rd_req_ready = 0; rd_data_valid = 0; wr_req_ready = 0; wr_data_ready = 0;
        p_rq = 0; p_rd = 0; p_wq = 0; p_wr = 0; r_wait = 0; w_wait = 0;
        rd_left = 0; wr_left = 0;
      end else begin
        rd_req_ready  = ($urandom % 2) == 0;
        rd_data_valid = (rd_left > 0) && (($urandom % 4) != 0);
        rd_data       = rd_data_valid ? mem[rd_ptr % MEMW] : '0;
        wr_req_ready  = ($urandom % 2) == 0;
        wr_data_ready = ($urandom % 4) != 0;
        if (rd_data_valid && !rd_data_ready) gap_rd++;
        if (wr_left > 0 && !wr_data_valid) gap_wr++;
        p_cyc   = cyc + 1;
        p_rq    = rd_req_valid && rd_req_ready;
        p_addr  = int'(rd_req_addr); p_len = int'(rd_req_len);
        p_rd    = rd_data_valid && rd_data_ready;
        p_wq    = wr_req_valid && wr_req_ready;
        p_waddr = int'(wr_req_addr); p_wlen = int'(wr_req_len);
        p_wr    = wr_data_valid && wr_data_ready;
        p_wdata = wr_data;
        r_wait  = rd_req_valid && !rd_req_ready; r_addr = int'(rd_req_addr);
        w_wait  = wr_req_valid && !wr_req_ready; w_addr = int'(wr_req_addr);
      end
    end
  end

  task automatic pulse_start(input int d);
    @(posedge clk); #2;
    dim_in = CW'(d); start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
  endtask

  task automatic run_case(input int d_in, input int pat, input bit poke);
    int n, t, done_cyc;
    int ra [MAXD*MAXD];
    int rb [MAXD*MAXD];
    int ex [MAXD*MAXD];
    string tl;
    n  = (d_in > MAXD) ? MAXD : d_in;
    tl = (d_in > MAXD) ? "R8" : (poke ? "R10" : "R2");
    for (int i = 0; i < n * n; i++) begin
      ra[i] = (pat == 0) ? int'($urandom_range(0, 200)) - 100 : int'($urandom);
      rb[i] = (pat == 0) ? int'($urandom_range(0, 200)) - 100 : int'($urandom);
      mem[BA + i] = ra[i];
      mem[BB + i] = rb[i];
      ex[i] = 0;
    end
    for (int i = 0; i < MAXD * MAXD + 8; i++) mem[BC + i] = 32'hDEAD_BEEF;
    // Reference: k outermost, rank-one updates
    for (int k = 0; k < n; k++)
      for (int i = 0; i < n; i++)
        for (int j = 0; j < n; j++)
          ex[i*n + j] += ra[i*n + k] * rb[k*n + j];
    clear_log();
    pulse_start(d_in);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    t = 0;
    while (!done && t < 40000) begin
      @(posedge clk); #2;
      t++;
      if (poke && t == 6) begin start = 1'b1; dim_in = CW'(5); end
      else start = 1'b0;
    end
    chk(t < 40000, "watchdog", t, 40000);
    done_cyc = cyc;
    @(posedge clk); #2;
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    chk(done_cyc == wr_last_cyc, "R6 done after last beat", done_cyc, wr_last_cyc);
    chk(rq_n == 2, {tl, " read request count"}, rq_n, 2);
    chk(rq_addr[0] == BA, "R2 first address", rq_addr[0], BA);
    chk(rq_len[0] == n * n, {tl, " first length"}, rq_len[0], n * n);
    chk(gap_rd == 0, "R2 read beat refused", gap_rd, 0);
    chk(rq_addr[1] == BB, "R3 second address", rq_addr[1], BB);
    chk(rq_before[1] == n * n, "R3 first fully read", rq_before[1], n * n);
    chk(wq_n == 1, "R5 write request count", wq_n, 1);
    chk(wq_addr == BC, "R5 write address", wq_addr, BC);
    chk(wq_len == n * n, {tl, " write length"}, wq_len, n * n);
    chk(gap_wr == 0, "R5 write stream gap", gap_wr, 0);
    chk(wq_cyc - last_rd_cyc >= n * n * n, "R5 write after compute", wq_cyc - last_rd_cyc, n * n * n);
    chk(hold_err == 0, "R9 request hold", hold_err, 0);
    for (int i = 0; i < n * n; i++)
      chk(mem[BC + i] == 32'(ex[i]), poke ? "R10 result" : "R4 result", mem[BC + i], 32'(ex[i]));
    chk(mem[BC + n * n] == 32'hDEAD_BEEF, "R5 no extra write", mem[BC + n * n], 32'hDEAD_BEEF);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(rd_req_valid == 1'b0, "R1 reset read request", rd_req_valid, 0);
    chk(wr_req_valid == 1'b0, "R1 reset write request", wr_req_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    for (int v = 0; v < NVEC; v++) run_case(TBL_DIM[v], TBL_PAT[v], 1'b0);

    // Directed: zero dimension (R7)
    clear_log();
    pulse_start(0);
    chk(done == 1'b1, "R7 immediate done", done, 1);
    repeat (10) @(posedge clk);
    #2;
    chk(rq_n + wq_n == 0, "R7 no transactions", rq_n + wq_n, 0);
    chk(done == 1'b0, "R7 done dropped", done, 0);
    chk(busy == 1'b0, "R1 idle after zero job", busy, 0);

    // Directed: start pulse in the middle of a job (R10)
    run_case(3, 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule